// File: doc/BRIEF.md
# ADC Ramp Pattern Checker

This block watches a two-lane (I and Q) ADC sample stream while the converter runs a counting test pattern. It carries one sample per lane on every clock. Each lane has its own checker. A checker waits for the first zero sample, and from then on it expects every sample to be one more than the sample before it. Any sample that breaks this rule adds one to that lane's error count. The ramp wraps from all ones back to zero without an error.

A single enable level controls both lanes. Holding it low clears the result. Raising it starts a fresh check. Host software pulses the enable low and then high, waits out a window that may last millions of samples, and reads the per-lane locked flags and error counts. A lane that never locked saw no zero. A locked lane with a zero count saw a clean ramp. During a check the lane not under test is normally held at all ones, so that lane never locks.

Top module: `adc_ramp_checker`

## Requirements
- R1: While `chk_en` is low at a clock edge, both lanes are unlocked and both error counts are zero after that edge. Reset gives the same state.
- R2: While enabled and unlocked, a lane locks at the edge where its sample equals zero. Its locked flag is 1 from the next cycle on. A non-zero sample leaves the lane unlocked.
- R3: Once a lane is locked, each later sample is compared with the previous sample plus one, modulo 2^W. Each mismatch adds exactly one to that lane's count, visible the cycle after the sample. A single corrupted sample between correct ramp values therefore counts two.
- R4: A step from all ones (2^W-1) to zero is a correct ramp step and counts no error.
- R5: After a mismatch, the expectation follows the received sample plus one. A forward jump in the ramp therefore counts as one error, and the ramp is tracked from its new value.
- R6: The error count saturates at 2^CNT_W-1 and never wraps.
- R7: The I and Q lanes have independent locked flags and counts. A lane held at all ones never locks and keeps a zero count.
- R8: An unlocked lane counts nothing, so its count reads zero.
- R9: Lock is kept for as long as the enable stays high. After the enable drops and rises again, a lane must see a new zero before it locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Check enable; low clears, high runs the check |
| adc_i | input | W | I-lane sample |
| adc_q | input | W | Q-lane sample |
| i_locked | output | 1 | I lane has seen its zero and is tracking |
| q_locked | output | 1 | Q lane has seen its zero and is tracking |
| i_err_cnt | output | CNT_W | I-lane saturating mismatch count |
| q_err_cnt | output | CNT_W | Q-lane saturating mismatch count |

## Verification
The properties assume that `chk_en` and the samples are stable and known at each rising edge. They also assume that reset is applied before the first edge that counts, because the checks are disabled only while reset is high. The stimulus drives every input on the falling edge and holds reset for the opening cycles. It also uses a narrow count width, so that saturation is reached in a few hundred cycles. The random traffic is mostly a clean ramp with occasional jumps, single glitches and enable drops. It starts each ramp a little below all ones, so that zero, and therefore lock, arrives within a short, bounded time.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;

    // Number of sample lanes handled by one checker instance.
    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_I = 0;
    localparam int unsigned LANE_Q = 1;

    // Per-lane tracking state.
    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,   // enable low, result cleared
        LANE_HUNT  = 2'd1,   // enabled, waiting for a zero sample
        LANE_TRACK = 2'd2    // locked, comparing against the ramp
    } lane_state_e;

    function automatic logic is_tracking(input lane_state_e st);
        return st == LANE_TRACK;
    endfunction

endpackage

// File: rtl/ramp_step_compare.sv
module ramp_step_compare #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] expected,
    output logic         is_zero,
    output logic         mismatch,
    output logic [W-1:0] next_exp
);
    // Successor of the received sample; natural W-bit wrap covers all-ones -> 0.
    always_comb begin
        is_zero  = (sample == '0);
        mismatch = (sample != expected);
        next_exp = sample + {{(W-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/ramp_sat_counter.sv
module ramp_sat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;
    assign at_max = (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && !at_max) begin
            count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/ramp_lane_checker.sv
module ramp_lane_checker
    import adc_ramp_pkg::*;
#(
    parameter int unsigned W     = 14,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [W-1:0]     sample,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt
);
    lane_state_e state_q;
    logic [W-1:0] exp_q;
    logic         smp_zero;
    logic         smp_bad;
    logic [W-1:0] smp_next;
    logic         cnt_inc;

    ramp_step_compare #(.W(W)) u_cmp (
        .sample   (sample),
        .expected (exp_q),
        .is_zero  (smp_zero),
        .mismatch (smp_bad),
        .next_exp (smp_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LANE_IDLE;
            exp_q   <= '0;
        end else if (!enable) begin
            state_q <= LANE_IDLE;
            exp_q   <= '0;
        end else begin
            // Expectation always follows the last received sample.
            exp_q <= smp_next;
            unique case (state_q)
                LANE_IDLE,
                LANE_HUNT:  state_q <= smp_zero ? LANE_TRACK : LANE_HUNT;
                LANE_TRACK: state_q <= LANE_TRACK;
                default:    state_q <= LANE_IDLE;
            endcase
        end
    end

    assign cnt_inc = enable && is_tracking(state_q) && smp_bad;

    ramp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (!enable),
        .inc   (cnt_inc),
        .count (err_cnt)
    );

    assign locked = is_tracking(state_q);
endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker
    import adc_ramp_pkg::*;
#(
    parameter int unsigned W     = 14,
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  logic [W-1:0]     adc_i,
    input  logic [W-1:0]     adc_q,
    output logic             i_locked,
    output logic             q_locked,
    output logic [CNT_W-1:0] i_err_cnt,
    output logic [CNT_W-1:0] q_err_cnt
);
    logic [LANES-1:0][W-1:0]     lane_smp;
    logic [LANES-1:0]            lane_lock;
    logic [LANES-1:0][CNT_W-1:0] lane_cnt;

    assign lane_smp[LANE_I] = adc_i;
    assign lane_smp[LANE_Q] = adc_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ramp_lane_checker #(.W(W), .CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .enable  (chk_en),
            .sample  (lane_smp[g]),
            .locked  (lane_lock[g]),
            .err_cnt (lane_cnt[g])
        );
    end

    assign i_locked  = lane_lock[LANE_I];
    assign q_locked  = lane_lock[LANE_Q];
    assign i_err_cnt = lane_cnt[LANE_I];
    assign q_err_cnt = lane_cnt[LANE_Q];
endmodule

// File: rtl/adc_ramp_checker_sva.sv
module adc_ramp_checker_sva #(
    parameter int unsigned W     = 14,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             chk_en,
    input logic [W-1:0]     adc_i,
    input logic [W-1:0]     adc_q,
    input logic             i_locked,
    input logic             q_locked,
    input logic [CNT_W-1:0] i_err_cnt,
    input logic [CNT_W-1:0] q_err_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r1_off_clears_i: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> (!i_locked && i_err_cnt == '0));
    a_r1_off_clears_q: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> (!q_locked && q_err_cnt == '0));

    a_r2_zero_locks_i: assert property (@(posedge clk) disable iff (rst)
        (chk_en && adc_i == '0) |=> i_locked);
    a_r2_zero_locks_q: assert property (@(posedge clk) disable iff (rst)
        (chk_en && adc_q == '0) |=> q_locked);

    a_r2_nonzero_waits_i: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !i_locked && adc_i != '0) |=> !i_locked);
    a_r2_nonzero_waits_q: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !q_locked && adc_q != '0) |=> !q_locked);

    a_r3_step_one_i: assert property (@(posedge clk) disable iff (rst)
        (chk_en && i_locked) |=> ((i_err_cnt - $past(i_err_cnt)) <= 1));
    a_r3_step_one_q: assert property (@(posedge clk) disable iff (rst)
        (chk_en && q_locked) |=> ((q_err_cnt - $past(q_err_cnt)) <= 1));

    a_r6_saturate_i: assert property (@(posedge clk) disable iff (rst)
        (chk_en && i_err_cnt == CMAX) |=> (i_err_cnt == CMAX));
    a_r6_saturate_q: assert property (@(posedge clk) disable iff (rst)
        (chk_en && q_err_cnt == CMAX) |=> (q_err_cnt == CMAX));

    a_r8_unlocked_quiet_i: assert property (@(posedge clk) disable iff (rst)
        !i_locked |-> (i_err_cnt == '0));
    a_r8_unlocked_quiet_q: assert property (@(posedge clk) disable iff (rst)
        !q_locked |-> (q_err_cnt == '0));

    a_r9_lock_held_i: assert property (@(posedge clk) disable iff (rst)
        (chk_en && i_locked) |=> i_locked);
    a_r9_lock_held_q: assert property (@(posedge clk) disable iff (rst)
        (chk_en && q_locked) |=> q_locked);
endmodule

bind adc_ramp_checker adc_ramp_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (chk_en),
    .adc_i     (adc_i),
    .adc_q     (adc_q),
    .i_locked  (i_locked),
    .q_locked  (q_locked),
    .i_err_cnt (i_err_cnt),
    .q_err_cnt (q_err_cnt)
);

// File: tb/adc_ramp_checker_tb_top.sv
module adc_ramp_checker_tb_top;
    localparam int unsigned W     = 14;
    localparam int unsigned CNT_W = 8;
    localparam logic [W-1:0]     ONES = '1;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chk_en = 1'b0;
    logic [W-1:0] adc_i = '0;
    logic [W-1:0] adc_q = '0;
    logic i_locked, q_locked;
    logic [CNT_W-1:0] i_err_cnt, q_err_cnt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // Reference state per lane, built from the requirements.
    logic             m_lock [2];
    logic [W-1:0]     m_exp  [2];
    logic [CNT_W-1:0] m_cnt  [2];

    always #2 clk = ~clk;   // 250 MHz

    adc_ramp_checker #(.W(W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .chk_en(chk_en), .adc_i(adc_i), .adc_q(adc_q),
        .i_locked(i_locked), .q_locked(q_locked),
        .i_err_cnt(i_err_cnt), .q_err_cnt(q_err_cnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input logic en, input logic [W-1:0] si, input logic [W-1:0] sq);
        for (int l = 0; l < 2; l++) begin
            logic [W-1:0] s;
            s = (l == 0) ? si : sq;
            if (rst || !en) begin
                m_lock[l] = 1'b0;
                m_cnt[l]  = '0;
            end else if (!m_lock[l]) begin
                if (s == '0) m_lock[l] = 1'b1;
            end else if (s != m_exp[l]) begin
                if (m_cnt[l] != CMAX) m_cnt[l] = m_cnt[l] + 1'b1;
            end
            m_exp[l] = s + 1'b1;
        end
    endtask

    task automatic compare_model();
        check(i_locked == m_lock[0], "R3", "model i_locked", i_locked, m_lock[0]);
        check(q_locked == m_lock[1], "R3", "model q_locked", q_locked, m_lock[1]);
        check(i_err_cnt == m_cnt[0], "R3", "model i_err_cnt", i_err_cnt, m_cnt[0]);
        check(q_err_cnt == m_cnt[1], "R3", "model q_err_cnt", q_err_cnt, m_cnt[1]);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic cycle(input logic en, input logic [W-1:0] si, input logic [W-1:0] sq);
        chk_en = en;
        adc_i  = si;
        adc_q  = sq;
        @(posedge clk);
        model_step(en, si, sq);
        @(negedge clk);
        compare_model();
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("  test done: total=%0d bad=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [W-1:0] ri, rq;
        void'($urandom(32'd20240611));
        for (int l = 0; l < 2; l++) begin
            m_lock[l] = 1'b0; m_exp[l] = '0; m_cnt[l] = '0;
        end
        @(negedge clk);
        for (int k = 0; k < 3; k++) cycle(1'b0, '0, '0);
        // R1: reset state
        check(!i_locked && !q_locked, "R1", "locked after reset", i_locked, 0);
        check(i_err_cnt == 0 && q_err_cnt == 0, "R1", "count after reset", i_err_cnt, 0);
        rst = 1'b0;

        // R1: enable low, zeros do not lock
        for (int k = 0; k < 4; k++) cycle(1'b0, '0, '0);
        check(!i_locked && !q_locked, "R1", "no lock while disabled", i_locked, 0);

        // R2/R8/R7: I ramp approaching zero, Q at all ones
        ri = ONES - 4;
        for (int k = 0; k < 5; k++) begin cycle(1'b1, ri, ONES); ri = ri + 1'b1; end
        check(!i_locked, "R2", "no lock before zero", i_locked, 0);
        check(i_err_cnt == 0, "R8", "no count before lock", i_err_cnt, 0);
        cycle(1'b1, ri, ONES); ri = ri + 1'b1;   // sample zero
        check(i_locked, "R2", "lock on zero", i_locked, 1);

        // R4: full ramp through the all-ones -> zero wrap
        for (int k = 0; k < (1 << W) + 9; k++) begin cycle(1'b1, ri, ONES); ri = ri + 1'b1; end
        check(i_err_cnt == 0, "R4", "wrap counts nothing", i_err_cnt, 0);
        check(!q_locked && q_err_cnt == 0, "R7", "all-ones lane stays idle", q_locked, 0);

        // R5: forward jump counts one
        ri = ri + 2;
        for (int k = 0; k < 3; k++) begin cycle(1'b1, ri, ONES); ri = ri + 1'b1; end
        check(i_err_cnt == 1, "R5", "jump counts one", i_err_cnt, 1);

        // R3: single corrupted sample counts two
        cycle(1'b1, ri, ONES); ri = ri + 1'b1;
        cycle(1'b1, ri ^ 14'h0155, ONES); ri = ri + 1'b1;
        cycle(1'b1, ri, ONES); ri = ri + 1'b1;
        cycle(1'b1, ri, ONES); ri = ri + 1'b1;
        check(i_err_cnt == 3, "R3", "glitch counts two", i_err_cnt, 3);

        // R1: drop enable clears
        cycle(1'b0, ri, ONES);
        check(!i_locked && i_err_cnt == 0, "R1", "disable clears", i_err_cnt, 0);

        // R9: re-enable needs a fresh zero
        cycle(1'b1, 14'd5, ONES);
        cycle(1'b1, 14'd6, ONES);
        cycle(1'b1, 14'd7, ONES);
        check(!i_locked, "R9", "no relock without zero", i_locked, 0);
        cycle(1'b1, 14'd0, ONES);
        check(i_locked, "R9", "relock on zero", i_locked, 1);

        // R6: constant sample mismatches every cycle -> saturation
        for (int k = 0; k < 300; k++) cycle(1'b1, 14'd5, ONES);
        check(i_err_cnt == CMAX, "R6", "count saturates", i_err_cnt, CMAX);

        // R7: Q locks and tracks on its own while I is saturated
        rq = '0;
        for (int k = 0; k < 20; k++) begin cycle(1'b1, 14'd5, rq); rq = rq + 1'b1; end
        check(q_locked && q_err_cnt == 0, "R7", "Q clean while I saturated", q_err_cnt, 0);
        check(i_err_cnt == CMAX, "R7", "I unaffected by Q", i_err_cnt, CMAX);

        // Random traffic against the reference
        ri = ONES - 14'($urandom_range(40, 0));
        rq = ONES - 14'($urandom_range(40, 0));
        for (int k = 0; k < 20000; k++) begin
            int p;
            logic en;
            logic [W-1:0] si, sq;
            p  = int'($urandom_range(999, 0));
            en = (p >= 5);
            si = ri; sq = rq;
            if (p >= 5 && p < 25)  si = 14'($urandom);
            if (p >= 25 && p < 40) sq = 14'($urandom);
            cycle(en, si, sq);
            ri = ri + 1'b1; rq = rq + 1'b1;
            if (p >= 40 && p < 50) ri = ri + 14'($urandom_range(9, 1));
            if (!en) begin
                ri = ONES - 14'($urandom_range(40, 0));
                rq = ONES - 14'($urandom_range(40, 0));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule